// File: doc/BRIEF.md
# Interruption Entry Sequencer

This block carries out the state save and control redirect that a processor performs when it takes an interruption. A one-cycle `start` pulse marks an interruption point. The block picks the cause there: a non-maskable transfer-of-control request first, then a synchronous trap reported by the pipeline, then an external interrupt if the status word allows it. It then snapshots the old status word and both instruction address queues into the saved control registers. When the old status word permits it, the block also captures the interrupted instruction word and copies seven general registers into shadow copies. Finally it computes the new status word and the new queues that point at the handler.

The instruction word is read through a single request/acknowledge port, and the sequence waits in a fetch state for as long as the memory takes. Address translation is not part of the block: a single `xlat_fail` input reports whether the lookup of the faulting address failed. A `done` pulse ends every sequence, including the case where nothing was taken. The parameter `WIDE_ARCH` selects the 64-bit variant (1) or the 32-bit variant (0).

States: `S_IDLE` waits for `start`. Start with a cause goes to `S_CAPTURE`; start with no cause goes straight to `S_FINISH`. `S_CAPTURE` goes to `S_FETCH` when an instruction read is needed and to `S_VECTOR` otherwise. `S_FETCH` goes to `S_VECTOR` on `imem_ack`. `S_VECTOR` goes to `S_FINISH`, and `S_FINISH` returns to `S_IDLE`.

Top module: `intr_entry_seq`

## Requirements
- R1: On `start`, the cause is chosen in this order. A pending `nmi_req` gives cause code 32 regardless of the interrupt-enable bit (status bit 0). Otherwise `trap_vld` gives `trap_cause`. Otherwise `ext_req` with status bit 0 set gives cause code 4. Otherwise nothing is taken: `taken` is 0 with `done`, and no saved register changes.
- R2: `done` is a one-cycle pulse. Counting from the clock edge that samples `start`, it rises after 1 edge when nothing is taken, after 3 edges without an instruction read, and after 4+d edges when the read is acknowledged d cycles after `imem_req` first shows.
- R3: `ipsw` receives the status word as it was at `start`.
- R4: `new_psw` is zero except for two bits. Bit 3 (wide) equals `dflt_wide` on the 64-bit variant and is always 0 on the 32-bit variant. Bit 4 (machine check) is set only for cause code 1.
- R5: On the 32-bit variant, `iiasq_f` and `iiasq_b` equal `iasq_f` and `iasq_b`. On the 64-bit variant with old status bit 2 (translation) set, both equal `iasq_f | iaoq_f[63:32]`. With bit 2 clear, both are zero.
- R6: `iiaoq_f` and `iiaoq_b` equal `iaoq_f` and `iaoq_b` as they were at `start`.
- R7: Shadow registers and `iir` change only when old status bit 1 (save-enable) is set. In that case `shadow[0..6]` receive `gr_in[0..6]`, the copies of general registers 1, 8, 9, 16, 17, 24 and 25 in that order.
- R8: Causes 12 to 22 and 26 to 28 load `iir` from the word read at `iaoq_f` with bits 1:0 cleared. If translation is on and `xlat_fail` is set, no read is made and `iir` becomes 0.
- R9: Causes 8 to 11 load `iir` from `dec_iir`. Every other cause leaves `iir` unchanged.
- R10: For every cause except 32, `new_iaoq_f` is `iva + 32*cause`. `new_iaoq_b` is always `new_iaoq_f + 4`, and `new_iasq_f` and `new_iasq_b` are always zero.
- R11: Cause 32 sets `new_iaoq_f` to `FW_ENTRY`. It pulses `gr_leak_en` with `done` and places the saved back space in `gr24_val` and the saved back offset in `gr25_val`.
- R12: `imem_req` stays high, with `imem_addr` stable, until `imem_ack`. It is never raised when save-enable was clear or the cause is outside the R8 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Interruption point pulse |
| nmi_req | input | 1 | Transfer-of-control request |
| ext_req | input | 1 | External interrupt request |
| trap_vld | input | 1 | Synchronous trap present |
| trap_cause | input | 6 | Trap cause code |
| cur_psw | input | 64 | Current status word |
| iasq_f | input | 32 | Front space queue entry |
| iasq_b | input | 32 | Back space queue entry |
| iaoq_f | input | 64 | Front offset queue entry |
| iaoq_b | input | 64 | Back offset queue entry |
| iva | input | 64 | Interruption vector base |
| dflt_wide | input | 1 | Default wide-mode bit |
| xlat_fail | input | 1 | Lookup of the front address failed |
| dec_iir | input | 32 | Instruction word held by the decoder |
| gr_in | input | 7x64 | General registers 1,8,9,16,17,24,25 |
| imem_req | output | 1 | Instruction read request |
| imem_addr | output | 64 | Word-aligned read address |
| imem_ack | input | 1 | Read response valid |
| imem_data | input | 32 | Read response word |
| done | output | 1 | Sequence complete pulse |
| taken | output | 1 | An interruption was taken (with done) |
| taken_cause | output | 6 | Cause code that was taken |
| ipsw | output | 64 | Saved status word |
| iiasq_f | output | 32 | Saved front space |
| iiasq_b | output | 32 | Saved back space |
| iiaoq_f | output | 64 | Saved front offset |
| iiaoq_b | output | 64 | Saved back offset |
| iir | output | 32 | Saved instruction word |
| shadow | output | 7x64 | Shadow register copies |
| new_psw | output | 64 | Status word for the handler |
| new_iasq_f | output | 32 | New front space |
| new_iasq_b | output | 32 | New back space |
| new_iaoq_f | output | 64 | New front offset |
| new_iaoq_b | output | 64 | New back offset |
| gr_leak_en | output | 1 | Write strobe for general registers 24/25 |
| gr24_val | output | 64 | Value for general register 24 |
| gr25_val | output | 64 | Value for general register 25 |

## Verification
In one `start` cycle, the priority pick (NMI over a trap over an external request) and the snapshot of the saved registers happen together. The bench raises `nmi_req`, `trap_vld` and `ext_req` at once, with the enable bit both set and clear, and checks that the taken cause and the vector match the winner while the saved queues hold the values present at that same edge. Instruction-read stalls of zero to two cycles are mixed into a sweep over all 64 cause codes. In that sweep, translation and lookup failure alternate, so the fetch and no-fetch paths are both judged against latency and `iir` values computed in the bench.

// File: rtl/ies_pkg.sv
package ies_pkg;
    localparam int CAUSE_W = 6;
    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t C_MCHK = 6'd1;
    localparam cause_t C_EXT  = 6'd4;
    localparam cause_t C_TOC  = 6'd32;

    localparam int PB_I = 0;
    localparam int PB_Q = 1;
    localparam int PB_C = 2;
    localparam int PB_W = 3;
    localparam int PB_M = 4;

    typedef enum logic [2:0] {S_IDLE, S_CAPTURE, S_FETCH, S_VECTOR, S_FINISH} st_t;
    typedef enum logic [1:0] {IIR_KEEP, IIR_DECODER, IIR_FETCH} iir_src_t;

    function automatic iir_src_t iir_source(cause_t c);
        if (c >= 6'd8 && c <= 6'd11)
            return IIR_DECODER;
        if ((c >= 6'd12 && c <= 6'd22) || (c >= 6'd26 && c <= 6'd28))
            return IIR_FETCH;
        return IIR_KEEP;
    endfunction
endpackage

// File: rtl/ies_cause_pick.sv
module ies_cause_pick
    import ies_pkg::*;
(
    input  logic   nmi_req,
    input  logic   trap_vld,
    input  cause_t trap_cause,
    input  logic   ext_req,
    input  logic   int_en,
    output logic   take,
    output cause_t cause
);
    always_comb begin
        take  = 1'b1;
        cause = C_TOC;
        if (nmi_req)
            cause = C_TOC;
        else if (trap_vld)
            cause = trap_cause;
        else if (ext_req && int_en)
            cause = C_EXT;
        else begin
            take  = 1'b0;
            cause = '0;
        end
    end
endmodule

// File: rtl/ies_space_fmt.sv
module ies_space_fmt #(
    parameter int XLEN      = 64,
    parameter bit WIDE_ARCH = 1'b1,
    localparam int SPW      = XLEN / 2
) (
    input  logic           xlat_on,
    input  logic [SPW-1:0] sq_f,
    input  logic [SPW-1:0] sq_b,
    input  logic [SPW-1:0] oq_f_hi,
    output logic [SPW-1:0] sv_f,
    output logic [SPW-1:0] sv_b
);
    logic [SPW-1:0] gva_hi;
    assign gva_hi = sq_f | oq_f_hi;

    generate
        if (WIDE_ARCH) begin : g_wide
            assign sv_f = xlat_on ? gva_hi : '0;
            assign sv_b = xlat_on ? gva_hi : '0;
        end else begin : g_narrow
            logic unused_ok;
            assign unused_ok = ^{xlat_on, gva_hi};
            assign sv_f = sq_f;
            assign sv_b = sq_b;
        end
    endgenerate
endmodule

// File: rtl/ies_vector_gen.sv
module ies_vector_gen
    import ies_pkg::*;
#(
    parameter int             XLEN      = 64,
    parameter bit             WIDE_ARCH = 1'b1,
    parameter logic [XLEN-1:0] FW_ENTRY = 64'h0000_0000_F000_0000
) (
    input  cause_t          cause,
    input  logic [XLEN-1:0] iva,
    input  logic            dflt_wide,
    output logic [XLEN-1:0] psw_out,
    output logic [XLEN-1:0] front,
    output logic [XLEN-1:0] back
);
    localparam int SLOT_SH = 5;

    always_comb begin
        psw_out       = '0;
        psw_out[PB_W] = WIDE_ARCH & dflt_wide;
        psw_out[PB_M] = (cause == C_MCHK);
        if (cause == C_TOC)
            front = FW_ENTRY;
        else
            front = iva + (XLEN'(cause) << SLOT_SH);
        back = front + XLEN'(4);
    end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import ies_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter bit              WIDE_ARCH = 1'b1,
    parameter int              N_SHADOW  = 7,
    parameter logic [XLEN-1:0] FW_ENTRY  = 64'h0000_0000_F000_0000,
    localparam int             SPW       = XLEN / 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           nmi_req,
    input  logic                           ext_req,
    input  logic                           trap_vld,
    input  logic [CAUSE_W-1:0]             trap_cause,
    input  logic [XLEN-1:0]                cur_psw,
    input  logic [SPW-1:0]                 iasq_f,
    input  logic [SPW-1:0]                 iasq_b,
    input  logic [XLEN-1:0]                iaoq_f,
    input  logic [XLEN-1:0]                iaoq_b,
    input  logic [XLEN-1:0]                iva,
    input  logic                           dflt_wide,
    input  logic                           xlat_fail,
    input  logic [31:0]                    dec_iir,
    input  logic [N_SHADOW-1:0][XLEN-1:0]  gr_in,
    output logic                           imem_req,
    output logic [XLEN-1:0]                imem_addr,
    input  logic                           imem_ack,
    input  logic [31:0]                    imem_data,
    output logic                           done,
    output logic                           taken,
    output logic [CAUSE_W-1:0]             taken_cause,
    output logic [XLEN-1:0]                ipsw,
    output logic [SPW-1:0]                 iiasq_f,
    output logic [SPW-1:0]                 iiasq_b,
    output logic [XLEN-1:0]                iiaoq_f,
    output logic [XLEN-1:0]                iiaoq_b,
    output logic [31:0]                    iir,
    output logic [N_SHADOW-1:0][XLEN-1:0]  shadow,
    output logic [XLEN-1:0]                new_psw,
    output logic [SPW-1:0]                 new_iasq_f,
    output logic [SPW-1:0]                 new_iasq_b,
    output logic [XLEN-1:0]                new_iaoq_f,
    output logic [XLEN-1:0]                new_iaoq_b,
    output logic                           gr_leak_en,
    output logic [XLEN-1:0]                gr24_val,
    output logic [XLEN-1:0]                gr25_val
);
    st_t             st, st_nx;
    cause_t          cause_q;
    logic            taken_q;
    logic [XLEN-1:0] psw_old;

    logic            pick_take;
    cause_t          pick_cause;
    logic [SPW-1:0]  sv_f, sv_b;
    logic [XLEN-1:0] vec_psw, vec_front, vec_back;
    iir_src_t        src;
    logic            fetch_go;

    ies_cause_pick u_pick (
        .nmi_req   (nmi_req),
        .trap_vld  (trap_vld),
        .trap_cause(trap_cause),
        .ext_req   (ext_req),
        .int_en    (cur_psw[PB_I]),
        .take      (pick_take),
        .cause     (pick_cause)
    );

    ies_space_fmt #(.XLEN(XLEN), .WIDE_ARCH(WIDE_ARCH)) u_space (
        .xlat_on(cur_psw[PB_C]),
        .sq_f   (iasq_f),
        .sq_b   (iasq_b),
        .oq_f_hi(iaoq_f[XLEN-1:SPW]),
        .sv_f   (sv_f),
        .sv_b   (sv_b)
    );

    ies_vector_gen #(.XLEN(XLEN), .WIDE_ARCH(WIDE_ARCH), .FW_ENTRY(FW_ENTRY)) u_vec (
        .cause    (cause_q),
        .iva      (iva),
        .dflt_wide(dflt_wide),
        .psw_out  (vec_psw),
        .front    (vec_front),
        .back     (vec_back)
    );

    assign src      = iir_source(cause_q);
    assign fetch_go = psw_old[PB_Q] && (src == IIR_FETCH) && !(psw_old[PB_C] && xlat_fail);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:    if (start) st_nx = pick_take ? S_CAPTURE : S_FINISH;
            S_CAPTURE: st_nx = fetch_go ? S_FETCH : S_VECTOR;
            S_FETCH:   if (imem_ack) st_nx = S_VECTOR;
            S_VECTOR:  st_nx = S_FINISH;
            S_FINISH:  st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        done        = (st == S_FINISH);
        imem_req    = (st == S_FETCH);
        taken       = taken_q;
        taken_cause = cause_q;
        gr_leak_en  = done && taken_q && (cause_q == C_TOC);
        new_iasq_f  = '0;
        new_iasq_b  = '0;
    end

    // save and vector datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q    <= '0;
            taken_q    <= 1'b0;
            psw_old    <= '0;
            ipsw       <= '0;
            iiasq_f    <= '0;
            iiasq_b    <= '0;
            iiaoq_f    <= '0;
            iiaoq_b    <= '0;
            iir        <= '0;
            shadow     <= '0;
            imem_addr  <= '0;
            new_psw    <= '0;
            new_iaoq_f <= '0;
            new_iaoq_b <= '0;
            gr24_val   <= '0;
            gr25_val   <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    taken_q <= pick_take;
                    if (pick_take) begin
                        cause_q   <= pick_cause;
                        psw_old   <= cur_psw;
                        ipsw      <= cur_psw;
                        iiasq_f   <= sv_f;
                        iiasq_b   <= sv_b;
                        iiaoq_f   <= iaoq_f;
                        iiaoq_b   <= iaoq_b;
                        imem_addr <= {iaoq_f[XLEN-1:2], 2'b00};
                        if (cur_psw[PB_Q]) shadow <= gr_in;
                    end
                end
                S_CAPTURE: if (psw_old[PB_Q]) begin
                    if (src == IIR_DECODER)
                        iir <= dec_iir;
                    else if (src == IIR_FETCH && psw_old[PB_C] && xlat_fail)
                        iir <= '0;
                end
                S_FETCH: if (imem_ack) iir <= imem_data;
                S_VECTOR: begin
                    new_psw    <= vec_psw;
                    new_iaoq_f <= vec_front;
                    new_iaoq_b <= vec_back;
                    if (cause_q == C_TOC) begin
                        gr24_val <= XLEN'(iiasq_b);
                        gr25_val <= iiaoq_b;
                    end
                end
                S_FINISH: ;
                default: ;
            endcase
        end
    end

    a_r1_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && start && nmi_req) |=> (taken_q && cause_q == C_TOC));

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_req && !imem_ack) |=> (imem_req && $stable(imem_addr)));

    a_r12_req_needs_save: assert property (@(posedge clk) disable iff (!rst_n)
        imem_req |-> psw_old[PB_Q]);

    a_r7_shadow_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && start && !cur_psw[PB_Q]) |=> $stable(shadow));

    a_r11_leak_value: assert property (@(posedge clk) disable iff (!rst_n)
        gr_leak_en |-> (gr25_val == iiaoq_b && gr24_val == XLEN'(iiasq_b)));
endmodule

// File: tb/tb_intr_entry_seq.sv
module tb_intr_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] FW = 64'h0000_0000_F000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic start = 0, nmi = 0, ext = 0, tvld = 0, dwide = 0, xfail = 0, ack = 0;
    logic [5:0] tcause = 0;
    logic [63:0] psw = 0, oqf = 0, oqb = 0, iva = 0;
    logic [31:0] sqf = 0, sqb = 0, dec = 0, rdata = 0;
    logic [6:0][63:0] gr = '0;

    logic req, done, tkn, leak;
    logic [63:0] addr, ipsw, ioqf, ioqb, npsw, noqf, noqb, g24, g25;
    logic [31:0] isqf, isqb, iir, nsqf, nsqb;
    logic [5:0] tc;
    logic [6:0][63:0] shd;

    logic n_req, n_done, n_tkn, n_leak;
    logic [63:0] n_addr, n_ipsw, n_ioqf, n_ioqb, n_npsw, n_noqf, n_noqb, n_g24, n_g25;
    logic [31:0] n_isqf, n_isqb, n_iir, n_nsqf, n_nsqb;
    logic [5:0] n_tc;
    logic [6:0][63:0] n_shd;

    intr_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .nmi_req(nmi), .ext_req(ext),
        .trap_vld(tvld), .trap_cause(tcause), .cur_psw(psw), .iasq_f(sqf), .iasq_b(sqb),
        .iaoq_f(oqf), .iaoq_b(oqb), .iva(iva), .dflt_wide(dwide), .xlat_fail(xfail),
        .dec_iir(dec), .gr_in(gr), .imem_req(req), .imem_addr(addr), .imem_ack(ack),
        .imem_data(rdata), .done(done), .taken(tkn), .taken_cause(tc), .ipsw(ipsw),
        .iiasq_f(isqf), .iiasq_b(isqb), .iiaoq_f(ioqf), .iiaoq_b(ioqb), .iir(iir),
        .shadow(shd), .new_psw(npsw), .new_iasq_f(nsqf), .new_iasq_b(nsqb),
        .new_iaoq_f(noqf), .new_iaoq_b(noqb), .gr_leak_en(leak), .gr24_val(g24), .gr25_val(g25));

    intr_entry_seq #(.WIDE_ARCH(1'b0)) dut_n (
        .clk(clk), .rst_n(rst_n), .start(start), .nmi_req(nmi), .ext_req(ext),
        .trap_vld(tvld), .trap_cause(tcause), .cur_psw(psw), .iasq_f(sqf), .iasq_b(sqb),
        .iaoq_f(oqf), .iaoq_b(oqb), .iva(iva), .dflt_wide(dwide), .xlat_fail(xfail),
        .dec_iir(dec), .gr_in(gr), .imem_req(n_req), .imem_addr(n_addr), .imem_ack(ack),
        .imem_data(rdata), .done(n_done), .taken(n_tkn), .taken_cause(n_tc), .ipsw(n_ipsw),
        .iiasq_f(n_isqf), .iiasq_b(n_isqb), .iiaoq_f(n_ioqf), .iiaoq_b(n_ioqb), .iir(n_iir),
        .shadow(n_shd), .new_psw(n_npsw), .new_iasq_f(n_nsqf), .new_iasq_b(n_nsqb),
        .new_iaoq_f(n_noqf), .new_iaoq_b(n_noqb), .gr_leak_en(n_leak), .gr24_val(n_g24), .gr25_val(n_g25));

    int checks = 0, errs = 0;
    bit finished = 0;

    // bench model state
    logic [31:0] m_iir = 0;
    logic [6:0][63:0] m_shd = '0;
    logic [63:0] m_ipsw = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int iir_kind(logic [5:0] c);
        // 0 keep, 1 decoder, 2 read
        if (c == 8 || c == 9 || c == 10 || c == 11) return 1;
        if ((c >= 12 && c <= 22) || c == 26 || c == 27 || c == 28) return 2;
        return 0;
    endfunction

    task automatic run_case(int delay, string lbl);
        bit e_take; logic [5:0] e_c; bit e_fetch; int kind;
        int cyc, reqs, wait_cnt, e_lat;
        logic [31:0] e_sqf, e_sqb;
        logic [63:0] e_front, e_psw, e_npsw;
        bit seen;
        if (nmi) begin e_take = 1; e_c = 32; end
        else if (tvld) begin e_take = 1; e_c = tcause; end
        else if (ext && psw[0]) begin e_take = 1; e_c = 4; end
        else begin e_take = 0; e_c = 0; end
        kind = iir_kind(e_c);
        e_fetch = e_take && psw[1] && kind == 2 && !(psw[2] && xfail);
        e_lat = !e_take ? 1 : (e_fetch ? 4 + delay : 3);

        @(negedge clk); start = 1;
        cyc = 0; reqs = 0; wait_cnt = 0; seen = 0;
        @(negedge clk); start = 0; cyc = 1;
        while (!done && cyc < 60) begin
            if (req) begin
                reqs++;
                if (reqs == 1) chk({"R8 read address ", lbl}, addr, {oqf[63:2], 2'b00});
                ack = (wait_cnt == delay);
                wait_cnt++;
            end else ack = 0;
            @(negedge clk); cyc++;
        end
        ack = 0;
        chk({"R2 done latency ", lbl}, cyc, e_lat);
        chk({"R12 read cycles ", lbl}, reqs, e_fetch ? delay + 1 : 0);
        chk({"R1 taken ", lbl}, tkn, e_take);
        if (e_take) begin
            chk({"R1 cause ", lbl}, tc, e_c);
            m_ipsw = psw;
            if (psw[1]) begin
                m_shd = gr;
                if (kind == 1) m_iir = dec;
                else if (kind == 2) m_iir = (psw[2] && xfail) ? 32'h0 : rdata;
            end
            e_sqf = psw[2] ? (sqf | oqf[63:32]) : 32'h0;
            e_sqb = e_sqf;
            chk({"R5 wide space f ", lbl}, isqf, e_sqf);
            chk({"R5 wide space b ", lbl}, isqb, e_sqb);
            chk({"R5 narrow space f ", lbl}, n_isqf, sqf);
            chk({"R5 narrow space b ", lbl}, n_isqb, sqb);
            chk({"R6 saved off f ", lbl}, ioqf, oqf);
            chk({"R6 saved off b ", lbl}, ioqb, oqb);
            e_front = (e_c == 32) ? FW : iva + 64'(e_c) * 64'd32;
            chk({"R10 R11 new front ", lbl}, noqf, e_front);
            chk({"R10 new back ", lbl}, noqb, e_front + 64'd4);
            chk({"R10 new spaces ", lbl}, {nsqf, nsqb}, 64'h0);
            e_psw = 0; e_psw[3] = dwide; e_psw[4] = (e_c == 1);
            e_npsw = 0; e_npsw[4] = (e_c == 1);
            chk({"R4 new psw wide ", lbl}, npsw, e_psw);
            chk({"R4 new psw narrow ", lbl}, n_npsw, e_npsw);
            chk({"R11 leak strobe ", lbl}, leak, e_c == 32);
            if (e_c == 32) begin
                chk({"R11 gr24 ", lbl}, g24, {32'h0, e_sqb});
                chk({"R11 gr25 ", lbl}, g25, oqb);
            end
        end
        chk({"R3 ipsw ", lbl}, ipsw, m_ipsw);
        chk({"R7 R8 R9 iir ", lbl}, iir, m_iir);
        chk({"R7 shadow ", lbl}, 64'(shd == m_shd), 64'd1);
        chk({"R9 narrow iir ", lbl}, n_iir, m_iir);
        @(negedge clk);
        chk({"R2 done one cycle ", lbl}, done, 0);
    endtask

    task automatic set_ctx(int k);
        sqf   = 32'h1000_0000 + 32'(k) * 32'h0101;
        sqb   = 32'h2000_0000 + 32'(k) * 32'h0303;
        oqf   = 64'h0000_00A0_0000_1003 + 64'(k) * 64'h0000_0001_0000_0104;
        oqb   = oqf + 64'd4;
        iva   = 64'h0000_0000_0004_0000 + 64'(k) * 64'h800;
        dec   = 32'hDEC0_0000 | 32'(k);
        rdata = 32'hA5A5_0000 | 32'(k);
        for (int j = 0; j < 7; j++) gr[j] = 64'(k) * 64'h100 + 64'(j);
    endtask

    initial begin
        int cyc_wd = 0;
        while (!finished) begin
            @(posedge clk); cyc_wd++;
            if (cyc_wd > 150000) begin
                errs++; checks++;
                $display("FAIL watchdog: actual=%0d expected<150000", cyc_wd);
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset done", done, 0);
        chk("R12 reset req", req, 0);
        chk("R3 reset ipsw", ipsw, 0);
        rst_n = 1;
        @(negedge clk);

        // sweep every cause code as a trap
        for (int c = 0; c < 64; c++) begin
            set_ctx(c);
            tvld = 1; tcause = 6'(c); nmi = 0; ext = 0;
            psw = 64'h0000_1234_0000_0002;
            psw[2] = (c % 3 == 0);
            xfail = c[0];
            dwide = c[1];
            run_case(c % 3, $sformatf("sweep c=%0d", c));
        end

        // save-enable clear: iir and shadows must hold (R7)
        set_ctx(70);
        tvld = 1; tcause = 6'd12; psw = 64'h0; xfail = 0; dwide = 1;
        run_case(0, "R7 save disabled fetch cause");
        tcause = 6'd9;
        run_case(0, "R7 save disabled decoder cause");

        // NMI beats everything, enable clear (R1, R11)
        set_ctx(71);
        nmi = 1; tvld = 1; tcause = 6'd14; ext = 1; psw = 64'h2; dwide = 0;
        run_case(0, "R1 nmi over trap and ext");
        nmi = 0;

        // trap beats external (R1)
        set_ctx(72);
        tvld = 1; tcause = 6'd9; ext = 1; psw = 64'h7;
        run_case(0, "R1 trap over ext");

        // external with enable set (R1)
        set_ctx(73);
        tvld = 0; ext = 1; psw = 64'h3;
        run_case(0, "R1 ext enabled");

        // external with enable clear: not taken, state holds (R1)
        set_ctx(74);
        tvld = 0; ext = 1; psw = 64'h6;
        run_case(0, "R1 ext masked");
        ext = 0; psw = 64'h1;
        run_case(0, "R1 nothing pending");

        // machine check with wide default (R4) and long stall (R12)
        set_ctx(75);
        tvld = 1; tcause = 6'd1; psw = 64'h2; dwide = 1;
        run_case(0, "R4 machine check");
        tcause = 6'd20; psw = 64'h6; xfail = 0;
        run_case(5, "R12 long stall");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule